// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

During hard reset this block acts as the configuration master. It walks a boot memory with a fixed run of single-byte reads, one on every 64-bit boundary, and packs the bytes into 32-bit configuration words. It builds one word for its own core and one for each of seven slave devices.

Each read is a simple strobe and ready handshake. The address is held until the memory answers. Only the lowest byte lane of the data bus is sampled, so the width of the boot port does not matter.

Once the last byte is in, the block raises a done flag and releases all eight words together. It also decodes the vector-base bit of its own word into the address of the system reset vector. Until then every result output reads as zero. A new reset starts the walk again at address 0.

Top module: `cfgw_fetcher`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `mem_rd` is 1, `mem_addr` is 0, `done` is 0, and `master_word`, `slave_words`, `vec_hi` and `reset_vec` are all zero.
- R2: A read is accepted on a clock edge where `mem_rd` and `mem_rdy` are both 1. Read n (n = 0..31) is presented at address 8*n. After the 32nd accepted read, `mem_rd` drops to 0 and stays 0, and `mem_addr` stays at 248.
- R3: While `mem_rd` is 1 and `mem_rdy` is 0, `mem_addr` and `mem_rd` hold their values.
- R4: Only `mem_data[7:0]` is captured. Upper data bits, and data presented while `mem_rdy` is 0, have no effect on any word.
- R5: Reads 4k..4k+3 form word k, with the first of the four in bits 31:24 and the fourth in bits 7:0. Word 0 appears on `master_word`. Word k (k = 1..7) appears on `slave_words[32*(k-1)+31 : 32*(k-1)]`.
- R6: `done` rises at the clock edge that accepts the 32nd read and stays 1 until the next reset.
- R7: While `done` is 0, `master_word`, `slave_words`, `vec_hi` and `reset_vec` are zero.
- R8: Bit 20 of the master word selects the vector base. When it is 0, `reset_vec` is 0x00000100. When it is 1, `reset_vec` is 0xFFF00100. `vec_hi` equals that bit while `done` is 1.
- R9: A synchronous reset at any point, including a cycle in which a read is being accepted, clears all words and restarts the sequence at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W (16) | Boot memory byte address |
| mem_rd | output | 1 | Read strobe, held until accepted |
| mem_rdy | input | 1 | Memory ready; accepts the current read |
| mem_data | input | DATA_W (64) | Read data; only bits 7:0 are used |
| master_word | output | 32 | Configuration word for this device |
| slave_words | output | 32*(NUM_WORDS-1) (224) | Slave words, slave 1 in the low 32 bits |
| done | output | 1 | All words fetched |
| vec_hi | output | 1 | Selected vector base is the high one |
| reset_vec | output | 32 | System reset vector address |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the capture of the final byte, and the rise of `done` together with the vector decode from that same byte group. The bench samples right after that edge and expects every word and the decoded vector to be complete in the same half cycle that `done` first reads 1.

The second pair is a reset and an accepted read. The bench holds `mem_rdy` high with data present while reset is applied part-way through a run. It then requires address 0 and cleared words, followed by a clean full run.

Runs with different wait-state counts and vector-bit values check the address hold and both vector bases.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    localparam int WORD_W       = 32;
    localparam int LANE_W       = 8;
    localparam int LANES        = WORD_W / LANE_W;
    localparam int NUM_WORDS    = 8;
    localparam int READ_STRIDE  = 8;
    localparam int VBASE_BIT    = 20;
    localparam int WIDX_W       = $clog2(NUM_WORDS);
    localparam int LIDX_W       = $clog2(LANES);

    localparam logic [WORD_W-1:0] BASE_LOW   = 32'h0000_0000;
    localparam logic [WORD_W-1:0] BASE_HIGH  = 32'hFFF0_0000;
    localparam logic [WORD_W-1:0] RESET_OFFS = 32'h0000_0100;

    typedef enum logic [0:0] {
        ST_FETCH = 1'b0,
        ST_DONE  = 1'b1
    } fetch_state_e;

    typedef struct packed {
        logic              valid;
        logic [WIDX_W-1:0] word;
        logic [LIDX_W-1:0] lane;
        logic [LANE_W-1:0] data;
    } byte_cap_t;

    function automatic logic [WORD_W-1:0] vector_addr(input logic hi);
        return (hi ? BASE_HIGH : BASE_LOW) | RESET_OFFS;
    endfunction

endpackage

// File: rtl/cfgw_seq.sv
module cfgw_seq
    import cfgw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NREADS = NUM_WORDS * LANES,
    parameter int STRIDE = READ_STRIDE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_rdy,
    input  logic [LANE_W-1:0] lane0,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output byte_cap_t         cap,
    output logic              done
);
    localparam int IDX_W = $clog2(NREADS);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NREADS - 1);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(STRIDE);

    fetch_state_e      state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;

    assign mem_rd   = (state_q == ST_FETCH);
    assign mem_addr = addr_q;
    assign done     = (state_q == ST_DONE);
    assign accept   = mem_rd && mem_rdy;

    always_comb begin
        cap.valid = accept;
        cap.word  = idx_q[IDX_W-1:LIDX_W];
        cap.lane  = idx_q[LIDX_W-1:0];
        cap.data  = lane0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            idx_q   <= '0;
            addr_q  <= '0;
        end else if (accept) begin
            if (idx_q == LAST_IDX) begin
                state_q <= ST_DONE;
            end else begin
                idx_q  <= idx_q + 1'b1;
                addr_q <= addr_q + STEP;
            end
        end
    end

    a_r3_hold_addr : assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

    a_r2_step_addr : assert property (@(posedge clk) disable iff (rst)
        (accept && !(idx_q == LAST_IDX)) |=> (mem_addr == $past(mem_addr) + STEP));

    a_r2_idle_after : assert property (@(posedge clk) disable iff (rst)
        done |=> (!mem_rd && $stable(mem_addr)));

endmodule

// File: rtl/cfgw_pack.sv
module cfgw_pack
    import cfgw_pkg::*;
#(
    parameter int NWORDS = NUM_WORDS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  byte_cap_t                     cap,
    output logic [NWORDS-1:0][WORD_W-1:0] shadow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (cap.valid) begin
            shadow[cap.word][LANE_W*(LANES-1-int'(cap.lane)) +: LANE_W] <= cap.data;
        end
    end

    a_r4_no_stray_write : assert property (@(posedge clk) disable iff (rst)
        !cap.valid |=> $stable(shadow));

endmodule

// File: rtl/cfgw_vec.sv
module cfgw_vec
    import cfgw_pkg::*;
(
    input  logic              done,
    input  logic [WORD_W-1:0] master,
    output logic              vec_hi,
    output logic [WORD_W-1:0] reset_vec
);
    always_comb begin
        vec_hi    = done && master[VBASE_BIT];
        reset_vec = done ? vector_addr(master[VBASE_BIT]) : '0;
    end
endmodule

// File: rtl/cfgw_fetcher.sv
module cfgw_fetcher
    import cfgw_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 64,
    parameter int NUM_WORDS = cfgw_pkg::NUM_WORDS,
    localparam int SLV_W    = (NUM_WORDS - 1) * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic              mem_rdy,
    input  logic [DATA_W-1:0] mem_data,
    output logic [WORD_W-1:0] master_word,
    output logic [SLV_W-1:0]  slave_words,
    output logic              done,
    output logic              vec_hi,
    output logic [WORD_W-1:0] reset_vec
);
    byte_cap_t                        cap;
    logic [NUM_WORDS-1:0][WORD_W-1:0] shadow;
    logic                             unused_hi_lanes;

    assign unused_hi_lanes = ^mem_data[DATA_W-1:LANE_W];

    cfgw_seq #(
        .ADDR_W (ADDR_W),
        .NREADS (NUM_WORDS * LANES),
        .STRIDE (READ_STRIDE)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .mem_rdy  (mem_rdy),
        .lane0    (mem_data[LANE_W-1:0]),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .cap      (cap),
        .done     (done)
    );

    cfgw_pack #(
        .NWORDS (NUM_WORDS)
    ) pack_i (
        .clk    (clk),
        .rst    (rst),
        .cap    (cap),
        .shadow (shadow)
    );

    always_comb begin
        master_word = done ? shadow[0] : '0;
        slave_words = '0;
        for (int k = 1; k < NUM_WORDS; k++) begin
            if (done) slave_words[WORD_W*(k-1) +: WORD_W] = shadow[k];
        end
    end

    cfgw_vec vec_i (
        .done      (done),
        .master    (master_word),
        .vec_hi    (vec_hi),
        .reset_vec (reset_vec)
    );

    a_r6_done_sticky : assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r8_vector_sel : assert property (@(posedge clk) disable iff (rst)
        done |-> (reset_vec == (master_word[VBASE_BIT] ? 32'hFFF0_0100 : 32'h0000_0100)));

    a_r7_quiet_before : assert property (@(posedge clk) disable iff (rst)
        !done |-> (reset_vec == '0 && !vec_hi));

endmodule

// File: tb/cfgw_fetcher_tb.sv
module cfgw_fetcher_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic [15:0]  mem_addr;
    logic         mem_rd;
    logic         mem_rdy;
    logic [63:0]  mem_data;
    logic [31:0]  master_word;
    logic [223:0] slave_words;
    logic         done;
    logic         vec_hi;
    logic [31:0]  reset_vec;

    int n_checks = 0;
    int n_fails  = 0;
    int addr_err, hold_err, zero_err;

    always #10 clk = ~clk;

    cfgw_fetcher dut_i (
        .clk         (clk),
        .rst         (rst),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_rdy     (mem_rdy),
        .mem_data    (mem_data),
        .master_word (master_word),
        .slave_words (slave_words),
        .done        (done),
        .vec_hi      (vec_hi),
        .reset_vec   (reset_vec)
    );

    // entry: {master word, wait states, expected reset vector}
    localparam logic [71:0] RUNS [4] = '{
        {32'h1234_5678, 8'd0, 32'hFFF0_0100},
        {32'h8000_00C3, 8'd2, 32'h0000_0100},
        {32'hFFEF_FFFF, 8'd1, 32'h0000_0100},
        {32'h0010_0000, 8'd3, 32'hFFF0_0100}
    };

    function automatic logic [31:0] exp_word(input logic [31:0] m, input int k);
        return (k == 0) ? m : 32'(m ^ (32'h0F1E_2D3C * k));
    endfunction

    function automatic logic [223:0] exp_slaves(input logic [31:0] m);
        logic [223:0] s;
        for (int k = 1; k < 8; k++) s[32*(k-1) +: 32] = exp_word(m, k);
        return s;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; mem_rdy = 1'b0; mem_data = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic serve(input logic [31:0] m, input int waits, input int nreads);
        addr_err = 0; hold_err = 0; zero_err = 0;
        for (int i = 0; i < nreads; i++) begin
            if (!mem_rd || mem_addr != 16'(i * 8)) addr_err++;
            if (done || master_word != 0 || slave_words != 0 || reset_vec != 0 || vec_hi)
                zero_err++;
            for (int w = 0; w < waits; w++) begin
                mem_rdy  = 1'b0;
                mem_data = {56'hDEAD_0000_BEEF_00, 8'hEE};
                @(negedge clk);
                if (!mem_rd || mem_addr != 16'(i * 8)) hold_err++;
            end
            mem_rdy  = 1'b1;
            mem_data = {56'hC3A5_5A3C_F00F_E1, 8'(exp_word(m, i / 4) >> (8 * (3 - i % 4)))};
            @(negedge clk);
        end
        mem_rdy = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; mem_rdy = 1'b0; mem_data = '0;
        @(negedge clk); @(negedge clk);
        // R1: state while reset is held
        check(mem_rd && mem_addr == 0 && !done, "R1 reset strobe/addr/done",
              {mem_rd, mem_addr, done}, {1'b1, 16'h0, 1'b0});
        check(master_word == 0 && slave_words == 0 && reset_vec == 0 && !vec_hi,
              "R1 reset outputs zero", {master_word, reset_vec}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(mem_rd && mem_addr == 0 && !done, "R1 first cycle after reset",
              {mem_rd, mem_addr, done}, {1'b1, 16'h0, 1'b0});

        for (int e = 0; e < 4; e++) begin
            logic [31:0] m;
            int          wt;
            logic [31:0] vexp;
            m    = RUNS[e][71:40];
            wt   = int'(RUNS[e][39:32]);
            vexp = RUNS[e][31:0];
            do_reset();
            serve(m, wt, 32);
            check(addr_err == 0, "R2 address sequence", addr_err, 0);
            if (wt > 0) check(hold_err == 0, "R3 hold during wait", hold_err, 0);
            check(zero_err == 0, "R7 outputs zero before done", zero_err, 0);
            check(done == 1'b1, "R6 done at last capture edge", done, 1);
            check(!mem_rd, "R2 strobe low after 32 reads", mem_rd, 0);
            check(master_word == m, "R5 master word packing", master_word, m);
            check(slave_words == exp_slaves(m), "R4 R5 slave words, upper lanes ignored",
                  slave_words, exp_slaves(m));
            check(reset_vec == vexp, "R8 reset vector", reset_vec, vexp);
            check(vec_hi == m[20], "R8 vector-base bit", vec_hi, m[20]);
            repeat (3) @(negedge clk);
            check(done && !mem_rd && mem_addr == 16'd248, "R6 done sticky, R2 idle",
                  {done, mem_rd, mem_addr}, {1'b1, 1'b0, 16'd248});
        end

        // R9: reset mid-sequence while a read is being accepted
        do_reset();
        serve(32'hA1B2_C3D4, 0, 10);
        mem_rdy  = 1'b1;
        mem_data = 64'hFF;
        rst      = 1'b1;
        @(negedge clk);
        check(mem_rd && mem_addr == 0 && !done, "R9 restart at address 0",
              {mem_rd, mem_addr, done}, {1'b1, 16'h0, 1'b0});
        rst = 1'b0; mem_rdy = 1'b0;
        serve(32'h0055_AA00, 1, 32);
        check(addr_err == 0 && master_word == 32'h0055_AA00, "R9 clean run after restart",
              master_word, 32'h0055_AA00);
        check(slave_words == exp_slaves(32'h0055_AA00), "R9 slave words after restart",
              slave_words, exp_slaves(32'h0055_AA00));

        // R9: reset after completion clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!done && master_word == 0 && slave_words == 0 && reset_vec == 0,
              "R9 reset after done clears words", {done, master_word}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule